// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the error bookkeeping of one CAN node. It holds an 8-bit transmit error counter and an 8-bit receive error counter. From these it derives the node's error state: error-active, error-passive or bus-off. The protocol engine beside it sends single-cycle event pulses for these conditions: a transmit error, a receive error, a successful transmission, a successful reception, and each detection of 11 consecutive recessive bits. The block answers with the counter values, the state, and per-direction warning and passive flags. It also gives a bus-off flag and a one-cycle error interrupt request whenever the state changes.

All outputs are registered. Each takes its new value at the clock edge that samples the event. Once the node is bus-off, it ignores every event except the recessive-idle pulse. After 128 of those pulses it clears both counters and rejoins the bus as error-active.

Top module: `can_fault_conf`

## Requirements
- R1: A transmit-error pulse adds 8 to the transmit counter. A sum that stays at or below 255 is stored unchanged.
- R2: A receive-error pulse adds 1 to the receive counter. The counter saturates at 255 and never triggers bus-off.
- R3: A transmit-ok or receive-ok pulse subtracts 1 from the matching counter and never goes below 0. When an error pulse and an ok pulse for the same counter arrive in the same cycle, the error wins.
- R4: `fc_state` shows error-passive (code 1) while either counter is above 127 and the node is not bus-off. `tx_passive` and `rx_passive` each flag their own counter above 127.
- R5: `fc_state` shows error-active (code 0) whenever both counters are 127 or below, including exactly 127.
- R6: A transmit error that would carry the transmit counter past 255 makes the node bus-off: `fc_state` shows code 2, `bus_off` is 1 and the transmit counter reads 255. While bus-off, error and ok pulses leave both counters unchanged.
- R7: In bus-off, the 128th recessive-idle pulse returns the node to error-active with both counters at 0. The 127th pulse does not. Recessive-idle pulses outside bus-off have no effect.
- R8: `tx_warn` and `rx_warn` are 1 exactly while their counter is 96 or more. At 95 they are 0.
- R9: `any_warn` is 1 while either counter is 96 or more. It returns to 0 only once both counters are below 96.
- R10: When `irq_en` is 1, every change of `fc_state` raises `err_irq` for exactly the one cycle in which the new state first appears. When `irq_en` is 0, a state change raises nothing.
- R11: While `rst` is high at a clock edge, both counters, all flags and `err_irq` go to 0, and the state goes to error-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_p | input | 1 | Transmit error event pulse |
| rx_err_p | input | 1 | Receive error event pulse |
| tx_ok_p | input | 1 | Successful transmission pulse |
| rx_ok_p | input | 1 | Successful reception pulse |
| idle11_p | input | 1 | 11 consecutive recessive bits seen |
| irq_en | input | 1 | Enable for the state-change interrupt |
| tx_cnt | output | 8 | Transmit error counter |
| rx_cnt | output | 8 | Receive error counter |
| fc_state | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| tx_warn | output | 1 | Transmit counter at 96 or more |
| rx_warn | output | 1 | Receive counter at 96 or more |
| any_warn | output | 1 | Either warning condition holds |
| tx_passive | output | 1 | Transmit counter above 127, not bus-off |
| rx_passive | output | 1 | Receive counter above 127 |
| bus_off | output | 1 | Node is bus-off |
| err_irq | output | 1 | One-cycle state-change interrupt request |

## Verification
The hardest situation to reach is the recovery boundary. The node must first be driven into bus-off through 32 transmit errors, with the passive and warning thresholds crossed on the way. It must then receive exactly 127 recessive-idle pulses before the deciding 128th. The bench reaches it by walking the counters with long runs of error pulses between the table vectors, checking each threshold as it passes. Along the way it interleaves ignored events: errors during bus-off and idle pulses while active. This shows that the recovery count and the frozen counters are not disturbed.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_counter.sv
// Saturating error counter with a step on error and unit decrement on success.
module can_fc_counter #(
  parameter int W    = 8,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  input  logic         clr,
  input  logic         hold,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W:0]   STEPV = (W+1)'(STEP);

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, cnt_q} + STEPV;
    ovf = 1'b0;
    if (clr) begin
      cnt_nxt = '0;
    end else if (hold) begin
      cnt_nxt = cnt_q;
    end else if (inc) begin
      ovf     = sum[W];
      cnt_nxt = sum[W] ? MAXV : sum[W-1:0];
    end else if (dec) begin
      cnt_nxt = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/can_fc_recovery.sv
// Counts recessive-idle pulses while bus-off; flags the final one.
module can_fc_recovery #(
  parameter int N = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int RW = (N > 1) ? $clog2(N) : 1;
  localparam logic [RW-1:0] LAST = RW'(N - 1);

  logic [RW-1:0] cnt;

  assign done = active && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active || done) cnt <= '0;
    else if (tick)              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/can_fc_state.sv
// Error state register, threshold flags and interrupt request.
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int W           = 8,
  parameter int PASSIVE_LIM = 127,
  parameter int WARN_LIM    = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tx_nxt,
  input  logic [W-1:0] rx_nxt,
  input  logic         tx_ovf,
  input  logic         rec_done,
  input  logic         irq_en,
  output fc_state_e    state_q,
  output logic         tx_warn,
  output logic         rx_warn,
  output logic         any_warn,
  output logic         tx_pass,
  output logic         rx_pass,
  output logic         bus_off,
  output logic         irq
);
  localparam logic [W-1:0] PLIM = W'(PASSIVE_LIM);
  localparam logic [W-1:0] WLIM = W'(WARN_LIM);

  fc_state_e state_d;
  logic      tw_d, rw_d;

  always_comb begin
    if (state_q == FC_BUSOFF) begin
      state_d = rec_done ? FC_ACTIVE : FC_BUSOFF;
    end else if (tx_ovf) begin
      state_d = FC_BUSOFF;
    end else if (tx_nxt > PLIM || rx_nxt > PLIM) begin
      state_d = FC_PASSIVE;
    end else begin
      state_d = FC_ACTIVE;
    end
    tw_d = (tx_nxt >= WLIM);
    rw_d = (rx_nxt >= WLIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= FC_ACTIVE;
      tx_warn  <= 1'b0;
      rx_warn  <= 1'b0;
      any_warn <= 1'b0;
      tx_pass  <= 1'b0;
      rx_pass  <= 1'b0;
      bus_off  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      state_q  <= state_d;
      tx_warn  <= tw_d;
      rx_warn  <= rw_d;
      any_warn <= tw_d | rw_d;
      tx_pass  <= (tx_nxt > PLIM) && (state_d != FC_BUSOFF);
      rx_pass  <= (rx_nxt > PLIM);
      bus_off  <= (state_d == FC_BUSOFF);
      irq      <= irq_en && (state_d != state_q);
    end
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int W            = 8,
  parameter int TX_STEP      = 8,
  parameter int RX_STEP      = 1,
  parameter int PASSIVE_LIM  = 127,
  parameter int WARN_LIM     = 96,
  parameter int RECOVER_IDLE = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_err_p,
  input  logic         rx_err_p,
  input  logic         tx_ok_p,
  input  logic         rx_ok_p,
  input  logic         idle11_p,
  input  logic         irq_en,
  output logic [W-1:0] tx_cnt,
  output logic [W-1:0] rx_cnt,
  output logic [1:0]   fc_state,
  output logic         tx_warn,
  output logic         rx_warn,
  output logic         any_warn,
  output logic         tx_passive,
  output logic         rx_passive,
  output logic         bus_off,
  output logic         err_irq
);
  fc_state_e    st;
  logic [W-1:0] tx_nxt, rx_nxt;
  logic         tx_ovf, rx_ovf_unused, rec_done, in_busoff;

  assign in_busoff = (st == FC_BUSOFF);
  assign fc_state  = st;

  can_fc_counter #(.W(W), .STEP(TX_STEP)) u_txc (
    .clk(clk), .rst(rst),
    .inc(tx_err_p), .dec(tx_ok_p & ~tx_err_p),
    .clr(rec_done), .hold(in_busoff),
    .cnt_q(tx_cnt), .cnt_nxt(tx_nxt), .ovf(tx_ovf)
  );

  can_fc_counter #(.W(W), .STEP(RX_STEP)) u_rxc (
    .clk(clk), .rst(rst),
    .inc(rx_err_p), .dec(rx_ok_p & ~rx_err_p),
    .clr(rec_done), .hold(in_busoff),
    .cnt_q(rx_cnt), .cnt_nxt(rx_nxt), .ovf(rx_ovf_unused)
  );

  can_fc_recovery #(.N(RECOVER_IDLE)) u_rec (
    .clk(clk), .rst(rst), .active(in_busoff), .tick(idle11_p), .done(rec_done)
  );

  can_fc_state #(.W(W), .PASSIVE_LIM(PASSIVE_LIM), .WARN_LIM(WARN_LIM)) u_st (
    .clk(clk), .rst(rst),
    .tx_nxt(tx_nxt), .rx_nxt(rx_nxt), .tx_ovf(tx_ovf), .rec_done(rec_done),
    .irq_en(irq_en), .state_q(st),
    .tx_warn(tx_warn), .rx_warn(rx_warn), .any_warn(any_warn),
    .tx_pass(tx_passive), .rx_pass(rx_passive), .bus_off(bus_off), .irq(err_irq)
  );
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker (
  input logic       clk,
  input logic       rst,
  input logic       tx_err_p,
  input logic       rx_err_p,
  input logic       irq_en,
  input logic [7:0] tx_cnt,
  input logic [7:0] rx_cnt,
  input logic [1:0] fc_state,
  input logic       tx_warn,
  input logic       any_warn,
  input logic       bus_off,
  input logic       err_irq
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R4
  passive_reason_chk: assert property (@(posedge clk) disable iff (rst)
    fc_state == 2'd1 |-> (tx_cnt > 8'd127 || rx_cnt > 8'd127));
  // R5
  active_reason_chk: assert property (@(posedge clk) disable iff (rst)
    fc_state == 2'd0 |-> (tx_cnt <= 8'd127 && rx_cnt <= 8'd127));
  // R6
  busoff_count_chk: assert property (@(posedge clk) disable iff (rst)
    bus_off |-> (fc_state == 2'd2 && tx_cnt == 8'd255));
  // R6
  busoff_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(bus_off) && bus_off) |-> ($stable(rx_cnt) && $stable(tx_cnt)));
  // R2
  rx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(rx_err_p) && !$past(bus_off) && $past(rx_cnt) != 8'd255)
      |-> rx_cnt == $past(rx_cnt) + 8'd1);
  // R8
  tx_warn_chk: assert property (@(posedge clk) disable iff (rst)
    tx_cnt >= 8'd96 |-> tx_warn);
  // R9
  any_warn_chk: assert property (@(posedge clk) disable iff (rst)
    any_warn |-> (tx_cnt >= 8'd96 || rx_cnt >= 8'd96));
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && err_irq) |-> (fc_state != $past(fc_state)));
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && fc_state != $past(fc_state) && $past(irq_en)) |-> err_irq);
endmodule

bind can_fault_conf can_fc_checker u_chk (.*);

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_err_p = 0, rx_err_p = 0, tx_ok_p = 0, rx_ok_p = 0, idle11_p = 0;
  logic irq_en = 0;
  logic [7:0] tx_cnt, rx_cnt;
  logic [1:0] fc_state;
  logic tx_warn, rx_warn, any_warn, tx_passive, rx_passive, bus_off, err_irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  can_fault_conf uut (
    .clk(clk), .rst(rst), .tx_err_p(tx_err_p), .rx_err_p(rx_err_p),
    .tx_ok_p(tx_ok_p), .rx_ok_p(rx_ok_p), .idle11_p(idle11_p), .irq_en(irq_en),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .fc_state(fc_state),
    .tx_warn(tx_warn), .rx_warn(rx_warn), .any_warn(any_warn),
    .tx_passive(tx_passive), .rx_passive(rx_passive), .bus_off(bus_off),
    .err_irq(err_irq)
  );

  // events {idle11, rx_ok, tx_ok, rx_err, tx_err}, expected tx, rx, state
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {5'b00001, 8'd8,  8'd0, 2'd0},   // R1
    {5'b00010, 8'd8,  8'd1, 2'd0},   // R2
    {5'b00101, 8'd16, 8'd1, 2'd0},   // R3 error wins
    {5'b01000, 8'd16, 8'd0, 2'd0},   // R3
    {5'b01000, 8'd16, 8'd0, 2'd0},   // R3 floor
    {5'b00100, 8'd15, 8'd0, 2'd0},   // R3
    {5'b10000, 8'd15, 8'd0, 2'd0},   // R7 idle ignored
    {5'b00011, 8'd23, 8'd1, 2'd0}    // R1 R2
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] ev);
    @(negedge clk);
    {idle11_p, rx_ok_p, tx_ok_p, rx_err_p, tx_err_p} = ev;
    @(posedge clk);
    #1;
    {idle11_p, rx_ok_p, tx_ok_p, rx_err_p, tx_err_p} = '0;
  endtask

  task automatic repeat_ev(input logic [4:0] ev, input int n);
    for (int i = 0; i < n; i++) step(ev);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11
    chk("R11 tx", tx_cnt, 0); chk("R11 rx", rx_cnt, 0); chk("R11 state", fc_state, 0);
    chk("R11 flags", {tx_warn, rx_warn, any_warn, tx_passive, rx_passive, bus_off, err_irq}, 0);
    @(negedge clk); rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][22:18]);
      chk($sformatf("R1-R3 vec%0d tx", v), tx_cnt, VEC[v][17:10]);
      chk($sformatf("R1-R3 vec%0d rx", v), rx_cnt, VEC[v][9:2]);
      chk($sformatf("R5 vec%0d state", v), fc_state, VEC[v][1:0]);
    end

    // tx 23 -> 95 : no warning yet (R8)
    repeat_ev(5'b00001, 9);
    chk("R8 tx95", tx_cnt, 95); chk("R8 warn at 95", tx_warn, 0); chk("R9 any at 95", any_warn, 0);
    step(5'b00001);
    chk("R8 warn at 103", tx_warn, 1); chk("R9 any at 103", any_warn, 1);
    repeat_ev(5'b00001, 3);
    chk("R5 at 127", fc_state, 0); chk("R5 tx127", tx_cnt, 127);
    irq_en = 1'b1;
    step(5'b00001);
    chk("R4 passive", fc_state, 1); chk("R4 tx_passive", tx_passive, 1);
    chk("R10 irq", err_irq, 1);
    step(5'b00000);
    chk("R10 one cycle", err_irq, 0);
    repeat_ev(5'b00100, 8);
    chk("R5 back active", fc_state, 0); chk("R10 irq back", err_irq, 1);
    irq_en = 1'b0;
    step(5'b00001);
    chk("R4 passive again", fc_state, 1); chk("R10 masked", err_irq, 0);
    repeat_ev(5'b00001, 15);
    chk("R1 tx255", tx_cnt, 255); chk("R6 not yet", bus_off, 0);
    irq_en = 1'b1;
    step(5'b00001);
    chk("R6 busoff", fc_state, 2); chk("R6 flag", bus_off, 1); chk("R6 tx", tx_cnt, 255);
    chk("R10 busoff irq", err_irq, 1); chk("R4 no tx_passive", tx_passive, 0);
    step(5'b01110);
    chk("R6 frozen rx", rx_cnt, 1); chk("R6 frozen tx", tx_cnt, 255);
    repeat_ev(5'b10000, 127);
    chk("R7 127 idle", fc_state, 2);
    step(5'b10000);
    chk("R7 recovered", fc_state, 0); chk("R7 tx0", tx_cnt, 0); chk("R7 rx0", rx_cnt, 0);
    chk("R10 recovery irq", err_irq, 1);

    // receive side
    do_reset();
    repeat_ev(5'b00010, 128);
    chk("R4 rx passive", fc_state, 1); chk("R4 rx_passive", rx_passive, 1);
    chk("R8 rx_warn", rx_warn, 1); chk("R9 any rx only", any_warn, 1); chk("R8 tx_warn", tx_warn, 0);
    repeat_ev(5'b00010, 128);
    chk("R2 saturate", rx_cnt, 255); chk("R2 no busoff", fc_state, 1);
    repeat_ev(5'b01000, 159);
    chk("R3 rx96", rx_cnt, 96); chk("R9 any still", any_warn, 1);
    step(5'b01000);
    chk("R8 rx_warn off", rx_warn, 0); chk("R9 any off", any_warn, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule